// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block is a clock-driven monostable pulse generator. It has two trigger inputs of opposite sense: one fires on a falling edge and one on a rising edge. Each input counts only while the other sits at its enabling level, so either input can act as an inhibit for the other. When a valid edge is accepted, the output goes high and stays high for a programmed number of clock cycles. It then drops on its own. A new valid edge during a pulse reloads the count, so the pulse is stretched to a full width after the last accepted edge.

An active-low clear input drives the output low at once. It never starts a pulse when it is released. After a clear, or after the synchronous reset, the block ignores triggers for a parameterised number of cycles. Both trigger inputs pass through two-stage synchronisers before edge detection, so the delay from an input change to the output rising is fixed and does not depend on the programmed width.

Top module: `retrig_oneshot`

## Requirements
- R1: After the synchronous reset `rst_n` is released, `pulse_q` is 0 and `pulse_qn` is 1 while no trigger has been accepted.
- R2: A falling edge on `trig_a_n` while `trig_b` is 1 and `clr_n` is 1 is a valid trigger.
- R3: A rising edge on `trig_b` while `trig_a_n` is 0 and `clr_n` is 1 is a valid trigger.
- R4: A falling edge on `trig_a_n` while `trig_b` is 0, and a rising edge on `trig_b` while `trig_a_n` is 1, start no pulse.
- R5: An accepted trigger holds `pulse_q` at 1 for exactly `width` cycles. `width` is captured when the trigger is accepted, and later changes of `width` do not alter the running pulse.
- R6: A `width` of 0 gives a pulse of exactly one cycle.
- R7: A valid trigger accepted while `pulse_q` is 1 restarts the count. `pulse_q` then stays 1 until `width` cycles after the last accepted trigger, with no gap.
- R8: A falling edge on `trig_a_n` and a rising edge on `trig_b` seen in the same cycle count as one trigger and give one pulse of `width` cycles.
- R9: While `clr_n` is 0, `pulse_q` is 0 and `pulse_qn` is 1. A fall of `clr_n` ends a running pulse at once, without waiting for a clock edge.
- R10: Releasing `clr_n` never starts a pulse, even when `trig_a_n` is 0 and `trig_b` is 1, and even when a trigger edge occurred while `clr_n` was 0.
- R11: After `clr_n` rises, a trigger input change is accepted only if it happens at least `REC_CYCLES` clock cycles after the release. Earlier edges are dropped.
- R12: `pulse_q` rises on the third rising clock edge after a valid input change (two synchroniser stages plus edge detection), for every `width` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the pulse, starts the recovery interval |
| trig_a_n | input | 1 | Falling-edge trigger, enabled while `trig_b` is high |
| trig_b | input | 1 | Rising-edge trigger, enabled while `trig_a_n` is low |
| width | input | WIDTH_W | Pulse length in clock cycles (0 is treated as 1) |
| pulse_q | output | 1 | Pulse output, high while timing |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
The hardest case to reach is the exact edge of the post-clear recovery window. Whether a trigger is accepted there depends on where the input change falls relative to the clear release, counted through two synchronisers on each path. The bench releases the clear on a known falling clock edge. It then moves the trigger change one cycle at a time, from the same cycle up to two cycles past the recovery length, and expects rejection below the threshold and a full pulse at and above it. Retrigger timing is reached the same way: the second edge is placed at each cycle offset inside a running pulse, and the total high time is checked against the offset plus the width.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the retriggerable one-shot.
// Assumes: nothing; holds only types and default constants.
package oneshot_pkg;

    // Default synchroniser depth for the asynchronous inputs.
    localparam int DEF_SYNC_STAGES = 2;

    // Qualified edge flags produced by the trigger detector.
    typedef struct packed {
        logic a_fall;   // falling edge of the low-active trigger, enabled
        logic b_rise;   // rising edge of the high-active trigger, enabled
    } trig_edges_t;

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
// Module: os_sync
// Purpose: multi-stage synchroniser for one asynchronous level.
// Assumes: STAGES >= 1; synchronous active-low reset loads RST_VAL into
// every stage so edge detection downstream sees no false transition.
module os_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture of the input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
`timescale 1ns/1ps
// Module: os_trig_detect
// Purpose: finds qualified trigger edges on synchronised inputs and merges
// them into a single fire strobe when the block is ready.
// Assumes: a_s and b_s are already synchronous to clk. History reset values
// (A low, B high) guarantee no edge can appear from reset values alone.
module os_trig_detect
    import oneshot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_s,
    input  logic        b_s,
    input  logic        ready,
    output trig_edges_t edges,
    output logic        fire
);

    logic a_prev;
    logic b_prev;

    // Keep one cycle of history for each synchronised input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev <= 1'b0;
            b_prev <= 1'b1;
        end else begin
            a_prev <= a_s;
            b_prev <= b_s;
        end
    end

    // Qualify each edge with the level of the opposite input.
    always_comb begin
        edges.a_fall = a_prev & ~a_s & b_s;
        edges.b_rise = ~b_prev & b_s & ~a_s;
    end

    // Any qualified edge in a cycle is one trigger, gated by readiness.
    assign fire = ready & (edges.a_fall | edges.b_rise);

endmodule

// File: rtl/os_clear_ctrl.sv
`timescale 1ns/1ps
// Module: os_clear_ctrl
// Purpose: handles the asynchronous clear: synchronises its release and
// holds off triggers for REC_CYCLES cycles after the release (and after reset).
// Assumes: clr_n may change at any time; assertion acts at once,
// release is seen after SYNC_STAGES clock edges.
module os_clear_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int REC_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic ready
);

    localparam int RW = (REC_CYCLES < 1) ? 1 : $clog2(REC_CYCLES + 1);
    localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYCLES);

    logic [SYNC_STAGES-1:0] rel_chain;
    logic                   clr_ok;
    logic [RW-1:0]          rec_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Release synchroniser, cleared at once by clr_n.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)      rel_chain <= 1'b0;
                else if (!rst_n) rel_chain <= 1'b0;
                else             rel_chain <= 1'b1;
            end
        end else begin : g_multi
            // Release synchroniser chain, cleared at once by clr_n.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)      rel_chain <= '0;
                else if (!rst_n) rel_chain <= '0;
                else             rel_chain <= {rel_chain[SYNC_STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign clr_ok = rel_chain[SYNC_STAGES-1];

    // Recovery countdown, reloaded while clear or reset is in force.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          rec_cnt <= REC_LOAD;
        else if (!rst_n)     rec_cnt <= REC_LOAD;
        else if (!clr_ok)    rec_cnt <= REC_LOAD;
        else if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
    end

    assign ready = clr_ok & (rec_cnt == '0);

endmodule

// File: rtl/os_pulse_timer.sv
`timescale 1ns/1ps
// Module: os_pulse_timer
// Purpose: counts the pulse length; loads on fire, counts down otherwise.
// Assumes: fire is synchronous; clr_n clears the count asynchronously so
// the output drops without a clock. A zero width loads as one.
module os_pulse_timer #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);

    logic [WIDTH_W-1:0] cnt;
    logic [WIDTH_W-1:0] load_val;

    // Map a zero width to a single cycle.
    always_comb begin
        load_val = (width == '0) ? WIDTH_W'(1) : width;
    end

    // Remaining-cycle counter; a fire always reloads, giving retrigger.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)         cnt <= '0;
        else if (!rst_n)    cnt <= '0;
        else if (fire)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
// Module: retrig_oneshot (top)
// Purpose: retriggerable monostable with two opposite-sense trigger inputs,
// an asynchronous clear and a post-clear recovery hold-off.
// Assumes: trigger inputs are asynchronous; latency from input change to
// pulse_q rising is SYNC_STAGES + 1 clock edges.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int REC_CYCLES  = 4,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               trig_a_n,
    input  logic               trig_b,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse_q,
    output logic               pulse_qn
);

    logic        a_s;
    logic        b_s;
    logic        ready;
    logic        fire;
    logic        active;
    trig_edges_t edges;

    os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_a (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trig_a_n),
        .q     (a_s)
    );

    os_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trig_b),
        .q     (b_s)
    );

    os_clear_ctrl #(.SYNC_STAGES(SYNC_STAGES), .REC_CYCLES(REC_CYCLES)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .ready (ready)
    );

    os_trig_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (a_s),
        .b_s   (b_s),
        .ready (ready),
        .edges (edges),
        .fire  (fire)
    );

    os_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .fire   (fire),
        .width  (width),
        .active (active)
    );

    assign pulse_q  = active;
    assign pulse_qn = ~active;

endmodule

// File: rtl/retrig_oneshot_chk.sv
`timescale 1ns/1ps
// Module: retrig_oneshot_chk
// Purpose: protocol checks on the one-shot, bound into the top module.
// Assumes: clr_n is sampled on clock edges for the recovery window count.
module retrig_oneshot_chk #(
    parameter int REC_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic clr_n,
    input logic fire,
    input logic pulse_q,
    input logic pulse_qn
);

    localparam int THRESH = SYNC_STAGES + REC_CYCLES;
    localparam int CW     = $clog2(THRESH + 1) + 1;
    localparam logic [CW-1:0] MAXV = CW'(THRESH);

    logic [CW-1:0] hi_cnt;

    // Count sampled edges with clear released, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n)  hi_cnt <= '0;
        else if (hi_cnt != MAXV) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (!pulse_q && pulse_qn)); // R9

    AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $past(fire)); // R10

    AST_FIRE_SETS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pulse_q || !clr_n)); // R7

    AST_END_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_q) && clr_n && $past(clr_n)) |-> !$past(fire)); // R5

    AST_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (hi_cnt >= MAXV)); // R11

endmodule

bind retrig_oneshot retrig_oneshot_chk #(
    .REC_CYCLES  (REC_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .fire     (fire),
    .pulse_q  (pulse_q),
    .pulse_qn (pulse_qn)
);

// File: tb/retrig_oneshot_tb.sv
`timescale 1ns/1ps
// Bench: sweeps widths, retrigger offsets and recovery offsets on a small
// configuration; expected pulse lengths are computed arithmetically.
module retrig_oneshot_tb;

    localparam int WW  = 4;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          trig_a_n = 1'b1;
    logic          trig_b = 1'b0;
    logic [WW-1:0] width = '0;
    logic          pulse_q;
    logic          pulse_qn;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    retrig_oneshot #(.WIDTH_W(WW), .REC_CYCLES(REC), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .trig_a_n (trig_a_n),
        .trig_b   (trig_b),
        .width    (width),
        .pulse_q  (pulse_q),
        .pulse_qn (pulse_qn)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive trigger levels at the current negedge (n=0) and measure the
    // length of the pulse that starts on the third clock edge. rt>0 adds a
    // trigger-B retrigger (low at rt-1, high at rt); wchg>=0 changes width at n=4.
    task automatic shot(input logic na, input logic nb, input int rt,
                        input int wchg, output int len);
        bit ended = 0;
        len = 0;
        trig_a_n = na;
        trig_b   = nb;
        for (int n = 1; n < 80; n++) begin
            @(negedge clk);
            if (n >= 3 && !ended) begin
                if (pulse_q) len++;
                else         ended = 1;
            end
            if (rt > 0 && n == rt - 1) trig_b = 1'b0;
            if (rt > 0 && n == rt)     trig_b = 1'b1;
            if (wchg >= 0 && n == 4)   width = WW'(wchg);
            if (ended && n > rt + 4) break;
        end
    endtask

    task automatic to_idle();
        trig_a_n = 1'b1;
        trig_b   = 1'b0;
        idle(6);
    endtask

    initial begin
        #(100000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len;
        int exp;
        idle(5);
        rst_n = 1'b1;
        idle(20);
        // R1: idle state after reset
        check("R1 pulse_q idle", int'(pulse_q), 0);
        check("R1 pulse_qn idle", int'(pulse_qn), 1);

        // R2 R3 R5 R6 R12: full width sweep, alternating trigger inputs
        for (int w = 0; w < (1 << WW); w++) begin
            width = WW'(w);
            exp = (w == 0) ? 1 : w;
            if (w % 2 == 0) begin
                trig_b = 1'b1; idle(4);
                shot(1'b0, 1'b1, 0, -1, len);
                check($sformatf("R2 R12 R5 R6 trigger A width %0d", w), len, exp);
            end else begin
                trig_a_n = 1'b0; idle(4);
                shot(1'b0, 1'b1, 0, -1, len);
                check($sformatf("R3 R12 R5 trigger B width %0d", w), len, exp);
            end
            to_idle();
        end

        // R4: gated edges are ignored
        width = WW'(5);
        shot(1'b0, 1'b0, 0, -1, len);
        check("R4 A fall with B low", len, 0);
        to_idle();
        shot(1'b1, 1'b1, 0, -1, len);
        check("R4 B rise with A high", len, 0);
        to_idle();

        // R8: both edges in one cycle give one pulse
        width = WW'(7);
        shot(1'b0, 1'b1, 0, -1, len);
        check("R8 simultaneous edges", len, 7);
        to_idle();

        // R5: width change during a pulse has no effect
        width = WW'(9);
        trig_b = 1'b1; idle(4);
        shot(1'b0, 1'b1, 0, 2, len);
        check("R5 width change mid pulse", len, 9);
        to_idle();

        // R7: retrigger at each offset inside a pulse of 6
        for (int rt = 2; rt <= 6; rt++) begin
            width = WW'(6);
            trig_b = 1'b1; idle(4);
            shot(1'b0, 1'b1, rt, -1, len);
            check($sformatf("R7 retrigger offset %0d", rt), len, rt + 6);
            to_idle();
        end

        // R9: clear ends a running pulse without a clock edge
        width = WW'(10);
        trig_b = 1'b1; idle(4);
        trig_a_n = 1'b0; idle(5);
        check("R9 pulse running before clear", int'(pulse_q), 1);
        #2 clr_n = 1'b0;
        #1;
        check("R9 pulse_q forced low", int'(pulse_q), 0);
        check("R9 pulse_qn forced high", int'(pulse_qn), 1);

        // R10: edge during clear, then release: no pulse
        @(negedge clk);
        trig_a_n = 1'b1; idle(3);
        trig_a_n = 1'b0; idle(4);
        clr_n = 1'b1;
        len = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pulse_q) len++;
        end
        check("R10 no pulse after clear release", len, 0);
        to_idle();

        // R11: recovery window sweep around the threshold
        for (int d = 0; d <= REC + 2; d++) begin
            width = WW'(3);
            trig_b = 1'b1; idle(4);
            clr_n = 1'b0; idle(3);
            clr_n = 1'b1;
            idle(d);
            shot(1'b0, 1'b1, 0, -1, len);
            check($sformatf("R11 trigger %0d cycles after release", d), len,
                  (d >= REC) ? 3 : 0);
            to_idle();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule